// File: doc/BRIEF.md
# SD/MMC Host Data FIFO with Threshold DMA Requests

This block is the data buffer between the processor side and the card side of an SD/MMC host controller. It is a circular FIFO of 32 words of 16 bits. The CPU reaches it through a small register port. The card-side transfer engine reaches it through a separate push/pop port. When data flows from the card (receive), the engine pushes and the CPU or a DMA channel drains. When data flows to the card (transmit), the CPU or DMA fills and the engine pops.

Two programmable fill thresholds watch the FIFO. The high-water mark applies to receive and the low-water mark applies to transmit. A threshold hit counts only in the matching transfer direction. Each direction has a DMA enable bit, and that bit decides where a hit goes: either to a registered DMA request line or to a flag bit in a status register. The status register is sticky and write-1-to-clear. Its other bits are set by event strobes from the rest of the controller. A mask register ANDs with the status register to form a single interrupt line.

Top module: `sdhost_fifo_dma`

## Requirements
- R1: Words leave the FIFO in the order they were accepted. The head entry is always visible on `eng_rdata_o`, and on `cpu_rdata_o` at address 0. A CPU read of address 0, or an engine pop, removes the head.
- R2: The FIFO holds up to DEPTH words, and `fifo_full_o` is high at DEPTH. A push from either side while full is dropped, and the stored data does not change.
- R3: A pop from either side while empty removes nothing, and `fifo_empty_o` stays high. The data returned is whatever the head slot last held, or 0 if that slot was never written.
- R4: Receive threshold. The buffer config register (address 3) has bit 15 = receive DMA enable and bits 12:8 = high-water mark. If `xfer_rx_i` is 1 and the fill level is above the high-water mark, the outcome depends on the receive DMA enable. When it is set, `dma_rx_req_o` goes high. When it is clear, status bit 10 is set. Either outcome appears one cycle after the state that caused it.
- R5: Transmit threshold. In the same register, bit 7 = transmit DMA enable and bits 4:0 = low-water mark. If `xfer_rx_i` is 0 and the fill level is below the low-water mark, the outcome depends on the transmit DMA enable. When it is set, `dma_tx_req_o` goes high. When it is clear, status bit 11 is set.
- R6: When a direction's threshold condition does not hold, its DMA request drops and its status flag clears, one cycle later.
- R7: While `xfer_act_i` is 0 and the FIFO is empty, both flags (bits 10 and 11) clear and both DMA requests are low, whatever the thresholds are.
- R8: A config write with bit 15 set clears status bit 10 at that same clock edge. A config write with bit 7 set clears status bit 11 at that same clock edge.
- R9: After reset the FIFO is empty, the status and mask registers read 0, and the config register reads 0x1F00 (high-water 31, low-water 0, both DMA enables off). Reserved config bits read 0, and addresses 4 and up read 0.
- R10: Writing the status register (address 1) clears each bit written as 1. `evt_set_i` sets status bits other than 10 and 11, and a set wins over a clear in the same cycle. Bits 10 and 11 follow only the threshold logic; a write of 1 clears them for one cycle.
- R11: `irq_o` is high exactly when the status register ANDed with the mask register (address 2) is nonzero.
- R12: In one cycle there is at most one push and at most one pop. If the CPU writes address 0 in the same cycle as an engine push, only the CPU word is stored. If the CPU reads address 0 in the same cycle as an engine pop, the head is removed once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_wr_i | input | 1 | CPU register write strobe |
| cpu_rd_i | input | 1 | CPU register read strobe (pops on address 0) |
| cpu_addr_i | input | ADDR_W | Register address: 0 data, 1 status, 2 mask, 3 buffer config |
| cpu_wdata_i | input | 16 | CPU write data |
| cpu_rdata_o | output | 16 | Register read data (combinational) |
| eng_push_i | input | 1 | Transfer engine push |
| eng_wdata_i | input | 16 | Transfer engine push data |
| eng_pop_i | input | 1 | Transfer engine pop |
| eng_rdata_o | output | 16 | FIFO head word |
| xfer_act_i | input | 1 | A data transfer is in progress |
| xfer_rx_i | input | 1 | Transfer direction: 1 receive, 0 transmit |
| evt_set_i | input | 16 | Status set strobes (bits 10 and 11 ignored) |
| fifo_full_o | output | 1 | FIFO holds DEPTH words |
| fifo_empty_o | output | 1 | FIFO holds no words |
| dma_rx_req_o | output | 1 | Receive DMA request, registered |
| dma_tx_req_o | output | 1 | Transmit DMA request, registered |
| irq_o | output | 1 | Interrupt, status AND mask |

## Verification
The bench builds the block with DEPTH = 32 and ADDR_W = 3. With these values the 5-bit threshold fields cover every fill level. Both the empty and full boundaries, and pointer wrap-around, are reached in a few dozen cycles. ADDR_W = 3 leaves four unused addresses that must read zero. The random phase moves the thresholds across the whole level range while both sides push and pop at the same time. This exercises threshold hits at level 0, at level 32, and at every level crossing under both settings of each DMA enable.

// File: rtl/hfq_pkg.sv
package hfq_pkg;
  localparam int unsigned REG_W = 16;
  localparam int unsigned THR_W = 5;

  localparam int unsigned RA_DATA = 0;
  localparam int unsigned RA_STAT = 1;
  localparam int unsigned RA_MASK = 2;
  localparam int unsigned RA_BUF  = 3;

  localparam int unsigned ST_RXF = 10;
  localparam int unsigned ST_TXF = 11;
  localparam logic [REG_W-1:0] FLAG_MASK = (REG_W'(1) << ST_RXF) | (REG_W'(1) << ST_TXF);

  localparam int unsigned CFG_RXEN  = 15;
  localparam int unsigned CFG_AF_LO = 8;
  localparam int unsigned CFG_TXEN  = 7;
  localparam int unsigned CFG_AE_LO = 0;

  typedef struct packed {
    logic             rx_en;
    logic [THR_W-1:0] af;
    logic             tx_en;
    logic [THR_W-1:0] ae;
  } buf_cfg_t;

  localparam buf_cfg_t CFG_RST = '{rx_en: 1'b0, af: '1, tx_en: 1'b0, ae: '0};
endpackage

// File: rtl/hfq_ring.sv
module hfq_ring #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned W     = 16,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  push_data_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [LW-1:0] lvl_q;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full_o  = (lvl_q == LW'(DEPTH));
  assign empty_o = (lvl_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rp_q];
  assign level_o = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (do_push) begin
        mem_q[wp_q] <= push_data_i;
        wp_q        <= ptr_inc(wp_q);
      end
      if (do_pop) rp_q <= ptr_inc(rp_q);
      lvl_q <= lvl_q + LW'(do_push) - LW'(do_pop);
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LW'(DEPTH)); // R2
  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> (full_o && $stable(head_o))); // R2
  AST_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> empty_o); // R3
endmodule

// File: rtl/hfq_thresh.sv
module hfq_thresh
  import hfq_pkg::*;
#(
  parameter int unsigned LW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [LW-1:0] level_i,
  input  buf_cfg_t      cfg_i,
  input  logic          act_i,
  input  logic          rx_i,
  output logic          rx_req_o,
  output logic          tx_req_o,
  output logic          rx_flag_o,
  output logic          tx_flag_o
);
  logic idle_empty, rx_hit, tx_hit;
  logic rx_req_q, tx_req_q;

  // an idle, empty FIFO quiets both directions
  assign idle_empty = !act_i && (level_i == '0);
  assign rx_hit     = rx_i  && (level_i > LW'(cfg_i.af)) && !idle_empty;
  assign tx_hit     = !rx_i && (level_i < LW'(cfg_i.ae)) && !idle_empty;
  assign rx_flag_o  = rx_hit && !cfg_i.rx_en;
  assign tx_flag_o  = tx_hit && !cfg_i.tx_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_req_q <= 1'b0;
      tx_req_q <= 1'b0;
    end else begin
      rx_req_q <= rx_hit && cfg_i.rx_en;
      tx_req_q <= tx_hit && cfg_i.tx_en;
    end
  end

  assign rx_req_o = rx_req_q;
  assign tx_req_o = tx_req_q;

  AST_REQ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rx_req_o, tx_req_o})); // R5
  AST_RX_REQ_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_req_o |-> ($past(cfg_i.rx_en) && $past(rx_i))); // R4
  AST_TX_REQ_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |-> ($past(cfg_i.tx_en) && !$past(rx_i))); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_i && level_i == '0) |=> (!rx_req_o && !tx_req_o)); // R7
endmodule

// File: rtl/hfq_stat.sv
module hfq_stat
  import hfq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] set_i,
  input  logic             rx_flag_i,
  input  logic             tx_flag_i,
  input  logic [REG_W-1:0] w1c_i,
  input  logic             clr_rx_i,
  input  logic             clr_tx_i,
  input  logic             mask_we_i,
  input  logic [REG_W-1:0] mask_i,
  output logic [REG_W-1:0] stat_o,
  output logic [REG_W-1:0] mask_o,
  output logic             irq_o
);
  logic [REG_W-1:0] stat_q, stat_d, mask_q;

  always_comb begin
    stat_d         = (stat_q & ~w1c_i) | (set_i & ~FLAG_MASK);
    stat_d[ST_RXF] = rx_flag_i & ~w1c_i[ST_RXF] & ~clr_rx_i;
    stat_d[ST_TXF] = tx_flag_i & ~w1c_i[ST_TXF] & ~clr_tx_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= stat_d;
      if (mask_we_i) mask_q <= mask_i;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign irq_o  = |(stat_q & mask_q);

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|w1c_i) |=> ((stat_q & $past(w1c_i & ~set_i)) == '0)); // R10
  AST_EVT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(set_i & ~FLAG_MASK)) |=>
      ((stat_q & $past(set_i & ~FLAG_MASK)) == $past(set_i & ~FLAG_MASK))); // R10
endmodule

// File: rtl/sdhost_fifo_dma.sv
module sdhost_fifo_dma
  import hfq_pkg::*;
#(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_wr_i,
  input  logic              cpu_rd_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [REG_W-1:0]  cpu_wdata_i,
  output logic [REG_W-1:0]  cpu_rdata_o,
  input  logic              eng_push_i,
  input  logic [REG_W-1:0]  eng_wdata_i,
  input  logic              eng_pop_i,
  output logic [REG_W-1:0]  eng_rdata_o,
  input  logic              xfer_act_i,
  input  logic              xfer_rx_i,
  input  logic [REG_W-1:0]  evt_set_i,
  output logic              fifo_full_o,
  output logic              fifo_empty_o,
  output logic              dma_rx_req_o,
  output logic              dma_tx_req_o,
  output logic              irq_o
);
  localparam int unsigned LW = $clog2(DEPTH + 1);

  logic             sel_data, sel_stat, sel_mask, sel_buf;
  logic             cfg_we, push, pop;
  logic [REG_W-1:0] push_data, head, stat, mask, w1c, cfg_rd;
  logic [LW-1:0]    level;
  logic             rx_flag, tx_flag;
  buf_cfg_t         cfg_q;

  assign sel_data = (cpu_addr_i == ADDR_W'(RA_DATA));
  assign sel_stat = (cpu_addr_i == ADDR_W'(RA_STAT));
  assign sel_mask = (cpu_addr_i == ADDR_W'(RA_MASK));
  assign sel_buf  = (cpu_addr_i == ADDR_W'(RA_BUF));
  assign cfg_we   = cpu_wr_i && sel_buf;

  // CPU side wins a shared push; pops collapse to one
  assign push      = (cpu_wr_i && sel_data) || eng_push_i;
  assign push_data = (cpu_wr_i && sel_data) ? cpu_wdata_i : eng_wdata_i;
  assign pop       = (cpu_rd_i && sel_data) || eng_pop_i;
  assign w1c       = (cpu_wr_i && sel_stat) ? cpu_wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= CFG_RST;
    else if (cfg_we) begin
      cfg_q.rx_en <= cpu_wdata_i[CFG_RXEN];
      cfg_q.af    <= cpu_wdata_i[CFG_AF_LO +: THR_W];
      cfg_q.tx_en <= cpu_wdata_i[CFG_TXEN];
      cfg_q.ae    <= cpu_wdata_i[CFG_AE_LO +: THR_W];
    end
  end

  always_comb begin
    cfg_rd                      = '0;
    cfg_rd[CFG_RXEN]            = cfg_q.rx_en;
    cfg_rd[CFG_AF_LO +: THR_W]  = cfg_q.af;
    cfg_rd[CFG_TXEN]            = cfg_q.tx_en;
    cfg_rd[CFG_AE_LO +: THR_W]  = cfg_q.ae;
  end

  always_comb begin
    cpu_rdata_o = '0;
    if (sel_data)      cpu_rdata_o = head;
    else if (sel_stat) cpu_rdata_o = stat;
    else if (sel_mask) cpu_rdata_o = mask;
    else if (sel_buf)  cpu_rdata_o = cfg_rd;
  end

  hfq_ring #(.DEPTH(DEPTH), .W(REG_W)) u_ring (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_data_i (push_data),
    .pop_i       (pop),
    .head_o      (head),
    .level_o     (level),
    .full_o      (fifo_full_o),
    .empty_o     (fifo_empty_o)
  );

  hfq_thresh #(.LW(LW)) u_thresh (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .level_i   (level),
    .cfg_i     (cfg_q),
    .act_i     (xfer_act_i),
    .rx_i      (xfer_rx_i),
    .rx_req_o  (dma_rx_req_o),
    .tx_req_o  (dma_tx_req_o),
    .rx_flag_o (rx_flag),
    .tx_flag_o (tx_flag)
  );

  hfq_stat u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (evt_set_i),
    .rx_flag_i (rx_flag),
    .tx_flag_i (tx_flag),
    .w1c_i     (w1c),
    .clr_rx_i  (cfg_we && cpu_wdata_i[CFG_RXEN]),
    .clr_tx_i  (cfg_we && cpu_wdata_i[CFG_TXEN]),
    .mask_we_i (cpu_wr_i && sel_mask),
    .mask_i    (cpu_wdata_i),
    .stat_o    (stat),
    .mask_o    (mask),
    .irq_o     (irq_o)
  );

  assign eng_rdata_o = head;

  AST_RXEN_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we && cpu_wdata_i[CFG_RXEN]) |=> !stat[ST_RXF]); // R8
  AST_TXEN_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we && cpu_wdata_i[CFG_TXEN]) |=> !stat[ST_TXF]); // R8
  AST_CPU_PUSH_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && sel_data && eng_push_i && fifo_empty_o) |=> (eng_rdata_o == $past(cpu_wdata_i))); // R12
endmodule

// File: tb/sim_sdhost_fifo_dma.sv
`timescale 1ns/1ps
module sim_sdhost_fifo_dma;
  localparam int DEPTH = 32;
  localparam int AW    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          cpu_wr = 0, cpu_rd = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [15:0]   cpu_wdata = '0, eng_wdata = '0, evt_set = '0;
  logic          eng_push = 0, eng_pop = 0, xact = 0, xrx = 0;
  logic [15:0]   cpu_rdata, eng_rdata;
  logic          full, empty, rreq, treq, irq;

  sdhost_fifo_dma #(.DEPTH(DEPTH), .ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cpu_wr_i(cpu_wr), .cpu_rd_i(cpu_rd),
    .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata),
    .eng_push_i(eng_push), .eng_wdata_i(eng_wdata), .eng_pop_i(eng_pop),
    .eng_rdata_o(eng_rdata), .xfer_act_i(xact), .xfer_rx_i(xrx),
    .evt_set_i(evt_set), .fifo_full_o(full), .fifo_empty_o(empty),
    .dma_rx_req_o(rreq), .dma_tx_req_o(treq), .irq_o(irq));

  int total = 0, bad = 0;

  // behavioural reference
  logic [15:0] m_q[$];
  logic [15:0] m_hist [DEPTH];
  int          m_pops = 0, m_push = 0;
  logic [15:0] m_stat = '0, m_mask = '0;
  logic        m_rxen = 0, m_txen = 0, m_rreq = 0, m_treq = 0;
  int          m_af = 31, m_ae = 0;

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] m_head();
    return m_hist[m_pops % DEPTH];
  endfunction

  function automatic logic [15:0] m_rd(input int a);
    case (a)
      0: return m_head();
      1: return m_stat;
      2: return m_mask;
      3: return {m_rxen, 2'b00, 5'(m_af), m_txen, 2'b00, 5'(m_ae)};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic model_step();
    int  lvl = m_q.size();
    bit  ie = !xact && lvl == 0;
    bit  rc = xrx && lvl > m_af && !ie;
    bit  tc = !xrx && lvl < m_ae && !ie;
    bit  cpush = cpu_wr && cpu_addr == 0;
    bit  cpop = cpu_rd && cpu_addr == 0;
    logic [15:0] w1c = (cpu_wr && cpu_addr == 1) ? cpu_wdata : 16'h0;
    logic [15:0] ns;
    ns = (m_stat & ~w1c) | (evt_set & ~16'h0C00);
    ns[10] = rc && !m_rxen && !w1c[10];
    ns[11] = tc && !m_txen && !w1c[11];
    if ((cpop || eng_pop) && lvl > 0) begin
      void'(m_q.pop_front());
      m_pops++;
    end
    if ((cpush || eng_push) && lvl < DEPTH) begin
      m_q.push_back(cpush ? cpu_wdata : eng_wdata);
      m_hist[m_push % DEPTH] = cpush ? cpu_wdata : eng_wdata;
      m_push++;
    end
    m_rreq = rc && m_rxen;
    m_treq = tc && m_txen;
    if (cpu_wr && cpu_addr == 2) m_mask = cpu_wdata;
    if (cpu_wr && cpu_addr == 3) begin
      m_rxen = cpu_wdata[15];
      m_af   = int'(cpu_wdata[12:8]);
      m_txen = cpu_wdata[7];
      m_ae   = int'(cpu_wdata[4:0]);
      if (cpu_wdata[15]) ns[10] = 1'b0;
      if (cpu_wdata[7])  ns[11] = 1'b0;
    end
    m_stat = ns;
  endtask

  task automatic compare();
    string t;
    case (int'(cpu_addr))
      0: t = "R1 cpu data";
      1: t = "R10 status";
      2: t = "R11 mask";
      3: t = "R9 config";
      default: t = "R9 unused addr";
    endcase
    chk(cpu_rdata, m_rd(int'(cpu_addr)), t);
    chk(eng_rdata, m_head(), "R1 head");
    chk({15'd0, full}, {15'd0, m_q.size() == DEPTH}, "R2 full");
    chk({15'd0, empty}, {15'd0, m_q.size() == 0}, "R3 empty");
    chk({15'd0, rreq}, {15'd0, m_rreq}, "R4 rx dma");
    chk({15'd0, treq}, {15'd0, m_treq}, "R5 tx dma");
    chk({15'd0, irq}, {15'd0, |(m_stat & m_mask)}, "R11 irq");
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    cpu_wr = 1; cpu_addr = AW'(a); cpu_wdata = d;
    tick();
    cpu_wr = 0;
  endtask

  task automatic rd0();
    cpu_rd = 1; cpu_addr = '0;
    tick();
    cpu_rd = 0;
  endtask

  task automatic peek_stat(input int bitn, input logic exp, input string tag);
    cpu_addr = AW'(1);
    #0.1;
    chk({15'd0, cpu_rdata[bitn]}, {15'd0, exp}, tag);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) m_hist[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cpu_addr = AW'(3);
    #0.1;
    chk(cpu_rdata, 16'h1F00, "R9 reset config");
    chk({14'd0, rreq, treq}, 16'h0, "R9 reset dma");
    chk({15'd0, irq}, 16'h0, "R9 reset irq");
    cpu_addr = AW'(5);
    #0.1;
    chk(cpu_rdata, 16'h0, "R9 unused addr");

    // underrun read
    rd0();
    chk({15'd0, empty}, 16'h1, "R3 empty after underrun read");
    chk(eng_rdata, 16'h0, "R3 underrun head");

    // transmit threshold
    xact = 1; xrx = 0;
    wr(3, 16'h1F04);
    tick();
    peek_stat(11, 1'b1, "R5 tx flag below low-water");
    wr(2, 16'h0800);
    chk({15'd0, irq}, 16'h1, "R11 irq on masked flag");
    for (int i = 0; i < 5; i++) wr(0, 16'h0100 + 16'(i));
    tick();
    peek_stat(11, 1'b0, "R6 tx flag drops above low-water");
    chk({15'd0, irq}, 16'h0, "R11 irq drops");
    wr(3, 16'h1F84);
    eng_pop = 1; tick(); tick(); eng_pop = 0;
    tick(); tick();
    chk({15'd0, treq}, 16'h1, "R5 tx dma request");
    peek_stat(11, 1'b0, "R5 no flag with dma");
    wr(3, 16'h1F04);
    tick();
    peek_stat(11, 1'b1, "R5 flag when dma off");
    wr(3, 16'h1F84);
    peek_stat(11, 1'b0, "R8 dma enable clears flag");

    // idle and empty
    xact = 0;
    eng_pop = 1; repeat (3) tick(); eng_pop = 0;
    tick(); tick();
    chk({15'd0, treq}, 16'h0, "R7 idle empty drops dma");
    wr(3, 16'h1F04);
    tick(); tick();
    peek_stat(11, 1'b0, "R7 idle empty no flag");

    // receive threshold
    xact = 1; xrx = 1;
    wr(3, 16'h8304);
    eng_push = 1;
    for (int i = 0; i < 5; i++) begin eng_wdata = 16'h0200 + 16'(i); tick(); end
    eng_push = 0;
    tick();
    chk({15'd0, rreq}, 16'h1, "R4 rx dma request");
    rd0(); rd0();
    tick();
    chk({15'd0, rreq}, 16'h0, "R6 rx dma drops");
    wr(3, 16'h0304);
    eng_push = 1; eng_wdata = 16'h0299; tick(); eng_push = 0;
    tick();
    peek_stat(10, 1'b1, "R4 rx flag when dma off");
    wr(3, 16'h8304);
    peek_stat(10, 1'b0, "R8 rx enable clears flag");
    while (!empty) rd0();

    // full boundary and ordering
    xact = 0; xrx = 0;
    for (int i = 0; i < DEPTH; i++) wr(0, 16'h1000 + 16'(i));
    chk({15'd0, full}, 16'h1, "R2 full at depth");
    wr(0, 16'hDEAD);
    eng_push = 1; eng_wdata = 16'hBEEF; tick(); eng_push = 0;
    for (int i = 0; i < DEPTH; i++) begin
      chk(eng_rdata, 16'h1000 + 16'(i), "R1 order after full");
      eng_pop = 1; tick(); eng_pop = 0;
    end
    chk({15'd0, empty}, 16'h1, "R2 extra words dropped");

    // simultaneous access
    cpu_wr = 1; cpu_addr = '0; cpu_wdata = 16'hAAAA;
    eng_push = 1; eng_wdata = 16'h5555;
    tick();
    cpu_wr = 0; eng_push = 0;
    chk(eng_rdata, 16'hAAAA, "R12 cpu push wins");
    cpu_rd = 1; eng_pop = 1; tick(); cpu_rd = 0; eng_pop = 0;
    chk({15'd0, empty}, 16'h1, "R12 single pop");

    // status set / clear
    evt_set = 16'h0001; tick(); evt_set = 16'h0;
    peek_stat(0, 1'b1, "R10 event sets bit");
    wr(1, 16'h0001);
    peek_stat(0, 1'b0, "R10 write one clears");
    evt_set = 16'h0002; wr(1, 16'h0002); evt_set = 16'h0;
    peek_stat(1, 1'b1, "R10 set wins over clear");
    wr(2, 16'h0002);
    chk({15'd0, irq}, 16'h1, "R11 irq from event bit");
    wr(1, 16'h0002);
    chk({15'd0, irq}, 16'h0, "R11 irq after clear");

    // random traffic
    for (int n = 0; n < 6000; n++) begin
      cpu_wr    = ($urandom % 4) == 0;
      cpu_rd    = ($urandom % 3) == 0;
      cpu_addr  = (($urandom % 2) == 0) ? AW'(0) : AW'($urandom % 8);
      cpu_wdata = 16'($urandom);
      eng_push  = ($urandom % 2) == 0;
      eng_wdata = 16'($urandom);
      eng_pop   = ($urandom % 2) == 0;
      evt_set   = (($urandom % 8) == 0) ? 16'($urandom) : 16'h0;
      if (($urandom % 40) == 0) xact = ~xact;
      if (($urandom % 60) == 0) xrx = ~xrx;
      tick();
    end
    cpu_wr = 0; cpu_rd = 0; eng_push = 0; eng_pop = 0; evt_set = 0;
    tick();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule